// File: doc/BRIEF.md
# Keyed Watchdog Timer with Early-Warning Interrupt

This block is a watchdog timer for a system controller. Software programs a period, enables the countdown and must then write a fixed restart word often enough to keep the timer from expiring. Every register write has to carry a register-specific key value in the written word; a write without the right key leaves the block untouched, so a stray or corrupted store cannot stop, reprogram or restart the timer by accident.

Time is counted in ticks of a slow (nominally 32 kHz) clock enable. One unit of the period field is `UNIT_TICKS` ticks. On expiry the block emits a reset request pulse of fixed length, which can also go out on an external reset pin with a selectable polarity. In dual mode, when the interrupt is enabled, the first expiry raises an interrupt and starts a second full period; the reset follows only if that second period also runs out without a restart. A separate software-reset register fires the reset pulse at once.

Top module: `wdog_keyed`

## Requirements
- R1: A write to offset 0x00 (mode) takes effect only when data bits [31:24] equal 0x22. Only the defined bits are stored and read back at offset 0x00 in the same positions: bit 0 enable, bit 1 pin polarity (1 = active high), bit 2 pin enable, bit 3 interrupt enable, bit 4 auto-start, bit 6 dual mode, bit 8 counter select; all other read bits are 0.
- R2: A write to offset 0x04 (length) takes effect only when data bits [4:0] equal 0x08; the period is taken from bits [5+PERIOD_W-1:5] and read back at offset 0x04 in the same position, with all other bits 0.
- R3: With enable set, the block fires the reset pulse exactly `period * UNIT_TICKS` tick cycles after the last counter load; a period of zero fires on the first tick.
- R4: Writing exactly 0x1971 to offset 0x08 restarts the countdown from the full period; any other value at that offset has no effect.
- R5: A keyed mode write and a keyed length write also restart the countdown from the (new) period.
- R6: With dual mode and interrupt enable both set, the first expiry raises `irq_o` and restarts the count, and the reset pulse fires only at the end of the second period; `irq_o` stays high until a restart write or a keyed mode write.
- R7: With dual mode set but interrupt enable clear, the first expiry fires the reset pulse and `irq_o` stays low.
- R8: Writing exactly 0x1209 to offset 0x14 raises `rst_req_o` at the next clock edge whether or not the timer is enabled; any other value there has no effect.
- R9: The reset pulse `rst_req_o` lasts `PULSE_TICKS` tick cycles.
- R10: `ext_rst_o` shows the active level (high when polarity is 1, low when 0) only while the pulse is active and pin enable is set; otherwise it holds the inactive level.
- R11: Clearing enable freezes the countdown, and the count does not move in cycles where `tick_en` is low.
- R12: After reset the mode register reads 0, the period reads all ones, and `irq_o` and `rst_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Slow-time tick enable, one clock wide per tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register byte offset of the write |
| wr_data | input | 32 | Write data including the key |
| rd_addr | input | ADDR_W | Register byte offset for the read |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| irq_o | output | 1 | Early-warning interrupt, held until cleared |
| rst_req_o | output | 1 | Active-high reset request pulse |
| ext_rst_o | output | 1 | External reset pin with programmed polarity |

## Verification
A table of keyed and unkeyed writes, including a mode word with only undefined bits set and a length word with a wrong low key, is read back to tell key rejection apart from bit masking. Directed runs then time the first reset against the programmed period with no restart, with a correct restart word, with a near-miss restart word, with a length rewrite mid-count, with a zero period and with ticks withheld, so an off-by-one in the count or a load that fails to happen gives a different edge count. Dual mode is run with and without the interrupt enable and with a restart between the interrupt and the second expiry, separating the two-stage path from the single-stage one. The software-reset word, its near miss, and the three pin settings show the pulse source and polarity apart.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

  // register offsets (byte addresses)
  localparam logic [7:0] OFS_MODE  = 8'h00;
  localparam logic [7:0] OFS_LEN   = 8'h04;
  localparam logic [7:0] OFS_KICK  = 8'h08;
  localparam logic [7:0] OFS_SWRST = 8'h14;

  // keys and magic words
  localparam logic [7:0]  MODE_KEY  = 8'h22;
  localparam logic [4:0]  LEN_KEY   = 5'h08;
  localparam logic [31:0] KICK_WORD = 32'h0000_1971;
  localparam logic [31:0] SWRST_WORD = 32'h0000_1209;

  // mode bit positions
  localparam int B_EN   = 0;
  localparam int B_POL  = 1;
  localparam int B_XEN  = 2;
  localparam int B_IRQ  = 3;
  localparam int B_AUTO = 4;
  localparam int B_DUAL = 6;
  localparam int B_CSEL = 8;

  localparam int MODE_W = 9;
  localparam logic [MODE_W-1:0] MODE_MASK = MODE_W'((1 << B_EN) | (1 << B_POL) |
    (1 << B_XEN) | (1 << B_IRQ) | (1 << B_AUTO) | (1 << B_DUAL) | (1 << B_CSEL));

  localparam int LEN_SHIFT = 5;

  typedef struct packed {
    logic en;
    logic pol;
    logic xen;
    logic irq_en;
    logic dual;
  } wdk_ctrl_t;

endpackage

// File: rtl/wdk_regs.sv
module wdk_regs
  import wdk_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int PERIOD_W = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [31:0]         wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [31:0]         rd_data,
  output wdk_ctrl_t           ctrl,
  output logic [PERIOD_W-1:0] period_nxt,
  output logic                load_stb,
  output logic                clr_irq_stb,
  output logic                sw_stb
);

  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] A_LEN   = ADDR_W'(OFS_LEN);
  localparam logic [ADDR_W-1:0] A_KICK  = ADDR_W'(OFS_KICK);
  localparam logic [ADDR_W-1:0] A_SWRST = ADDR_W'(OFS_SWRST);

  logic [MODE_W-1:0]   mode_q, mode_d;
  logic [PERIOD_W-1:0] period_q, period_d;
  logic                mode_hit, len_hit, kick_hit, sw_hit;

  // write decode with key checks
  always_comb begin
    mode_hit = wr_en && (wr_addr == A_MODE)  && (wr_data[31:24] == MODE_KEY);
    len_hit  = wr_en && (wr_addr == A_LEN)   && (wr_data[4:0] == LEN_KEY);
    kick_hit = wr_en && (wr_addr == A_KICK)  && (wr_data == KICK_WORD);
    sw_hit   = wr_en && (wr_addr == A_SWRST) && (wr_data == SWRST_WORD);
  end

  // next state
  always_comb begin
    mode_d   = mode_q;
    period_d = period_q;
    if (mode_hit) mode_d = wr_data[MODE_W-1:0] & MODE_MASK;
    if (len_hit)  period_d = wr_data[LEN_SHIFT +: PERIOD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      period_q <= '1;
    end else begin
      mode_q   <= mode_d;
      period_q <= period_d;
    end
  end

  // outputs toward the counter
  always_comb begin
    period_nxt  = period_d;
    load_stb    = mode_hit | len_hit | kick_hit;
    clr_irq_stb = mode_hit | kick_hit;
    sw_stb      = sw_hit;
    ctrl.en     = mode_q[B_EN];
    ctrl.pol    = mode_q[B_POL];
    ctrl.xen    = mode_q[B_XEN];
    ctrl.irq_en = mode_q[B_IRQ];
    ctrl.dual   = mode_q[B_DUAL];
  end

  // read mux
  always_comb begin
    case (rd_addr)
      A_MODE:  rd_data = 32'(mode_q);
      A_LEN:   rd_data = 32'(period_q) << LEN_SHIFT;
      default: rd_data = '0;
    endcase
  end

  // R1: unkeyed mode write leaves the mode register alone
  p_mode_key_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_MODE && wr_data[31:24] != MODE_KEY) |=> $stable(mode_q));

  // R2: unkeyed length write leaves the period alone
  p_len_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_LEN && wr_data[4:0] != LEN_KEY) |=> $stable(period_q));

endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
  parameter int PERIOD_W   = 11,
  parameter int UNIT_TICKS = 512
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                run,
  input  logic                dual_sel,
  input  logic                load,
  input  logic [PERIOD_W-1:0] load_period,
  input  logic                clr_irq,
  output logic                irq,
  output logic                fire
);

  localparam int UNIT_SH = $clog2(UNIT_TICKS);
  localparam int CNT_W   = PERIOD_W + UNIT_SH;

  logic [CNT_W-1:0] cnt_q, cnt_d, reload_v;
  logic             stage_q, stage_d;
  logic             irq_q, irq_d;
  logic             step, expire;

  always_comb begin
    reload_v = CNT_W'(load_period) << UNIT_SH;
    step     = run && tick && !load;
    expire   = step && (cnt_q <= CNT_W'(1));
  end

  always_comb begin
    cnt_d   = cnt_q;
    stage_d = stage_q;
    irq_d   = irq_q;
    fire    = 1'b0;
    if (clr_irq) irq_d = 1'b0;
    if (load) begin
      cnt_d   = reload_v;
      stage_d = 1'b0;
    end else if (expire) begin
      cnt_d = reload_v;
      if (dual_sel && !stage_q) begin
        stage_d = 1'b1;
        irq_d   = 1'b1;
      end else begin
        stage_d = 1'b0;
        fire    = 1'b1;
      end
    end else if (step) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      stage_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      stage_q <= stage_d;
      irq_q   <= irq_d;
    end
  end

  assign irq = irq_q;

  // R3: each enabled tick above one moves the count down by exactly one
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !load && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R11: the count holds while stopped
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt_q));

  // R6: the interrupt only rises in dual mode with interrupt enable
  p_irq_dual_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(dual_sel));

  // R6: the interrupt stays up without a clear
  p_irq_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !clr_irq) |=> irq_q);

endmodule

// File: rtl/wdk_pulse.sv
module wdk_pulse #(
  parameter int PULSE_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic fire,
  input  logic sw_fire,
  input  logic xen,
  input  logic pol,
  output logic rst_req,
  output logic ext_rst
);

  localparam int PC_W = $clog2(PULSE_TICKS + 1);

  logic [PC_W-1:0] pcnt_q, pcnt_d;
  logic            active;

  always_comb begin
    pcnt_d = pcnt_q;
    if (fire || sw_fire) pcnt_d = PC_W'(PULSE_TICKS);
    else if (tick && pcnt_q != '0) pcnt_d = pcnt_q - PC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  always_comb begin
    rst_req = (pcnt_q != '0);
    active  = rst_req && xen;
    ext_rst = pol ? active : !active;
  end

  // R9: the pulse counter never exceeds the programmed length
  p_len_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= PC_W'(PULSE_TICKS));

  // R9: the pulse cannot end without a tick
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && !tick) |=> rst_req);

  // R8: a software reset request shows on the next edge
  p_sw_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_fire |=> rst_req);

endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdk_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int PERIOD_W    = 11,
  parameter int UNIT_TICKS  = 512,
  parameter int PULSE_TICKS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              irq_o,
  output logic              rst_req_o,
  output logic              ext_rst_o
);

  logic                rst_meta_q, rst_sync_q;
  wdk_ctrl_t           ctrl;
  logic [PERIOD_W-1:0] period_nxt;
  logic                load_stb, clr_irq_stb, sw_stb, fire;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  wdk_regs #(.ADDR_W(ADDR_W), .PERIOD_W(PERIOD_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .ctrl       (ctrl),
    .period_nxt (period_nxt),
    .load_stb   (load_stb),
    .clr_irq_stb(clr_irq_stb),
    .sw_stb     (sw_stb)
  );

  wdk_counter #(.PERIOD_W(PERIOD_W), .UNIT_TICKS(UNIT_TICKS)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .tick       (tick_en),
    .run        (ctrl.en),
    .dual_sel   (ctrl.dual & ctrl.irq_en),
    .load       (load_stb),
    .load_period(period_nxt),
    .clr_irq    (clr_irq_stb),
    .irq        (irq_o),
    .fire       (fire)
  );

  wdk_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .tick   (tick_en),
    .fire   (fire),
    .sw_fire(sw_stb),
    .xen    (ctrl.xen),
    .pol    (ctrl.pol),
    .rst_req(rst_req_o),
    .ext_rst(ext_rst_o)
  );

  // R10: with no pulse the pin rests at the inactive level
  p_pin_idle_r10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !rst_req_o |-> (ext_rst_o == !ctrl.pol));

  // R10: with the pin disabled it never shows the active level
  p_pin_off_r10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !ctrl.xen |-> (ext_rst_o == !ctrl.pol));

endmodule

// File: tb/wdog_keyed_tb.sv
module wdog_keyed_tb;

  localparam int AW = 5;
  localparam int PW = 8;
  localparam int UT = 4;
  localparam int PT = 16;

  logic          clk, rst_n, tick_en, wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [31:0]   wr_data, rd_data;
  logic          irq_o, rst_req_o, ext_rst_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  wdog_keyed #(.ADDR_W(AW), .PERIOD_W(PW), .UNIT_TICKS(UT), .PULSE_TICKS(PT)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o),
    .rst_req_o(rst_req_o), .ext_rst_o(ext_rst_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [7:0]  a;
    logic [31:0] d;
    logic [7:0]  ra;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{8'h00, 32'h2200_0048, 8'h00, 32'h0000_0048},  // R1 keyed dual+irq
    '{8'h00, 32'h2100_0001, 8'h00, 32'h0000_0048},  // R1 wrong key ignored
    '{8'h00, 32'h2200_015E, 8'h00, 32'h0000_015E},  // R1 all defined bits but enable
    '{8'h00, 32'h2200_00A0, 8'h00, 32'h0000_0000},  // R1 undefined bits dropped
    '{8'h04, 32'h0000_00A8, 8'h04, 32'h0000_00A0},  // R2 period 5
    '{8'h04, 32'h0000_00E9, 8'h04, 32'h0000_00A0},  // R2 wrong low key ignored
    '{8'h04, 32'h0000_E0E8, 8'h04, 32'h0000_00E0}   // R2 bits above the field dropped
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[AW-1:0]; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; tick_en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
  endtask

  // count edges until the chosen output is high (sel 0: rst_req_o, 1: irq_o)
  task automatic wait_hi(input int sel, input int limit, output int n);
    n = 0;
    while (n < limit) begin
      @(posedge clk); #1;
      n++;
      if ((sel == 0) ? rst_req_o : irq_o) break;
    end
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) begin @(posedge clk); #1; end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int n;
    // R12 reset state
    do_reset();
    chk("R12 irq", {31'b0, irq_o}, 0);
    chk("R12 rst_req", {31'b0, rst_req_o}, 0);
    chk("R12 pin idle", {31'b0, ext_rst_o}, 1);
    rd_addr = 5'h00; #1; chk("R12 mode", rd_data, 0);
    rd_addr = 5'h04; #1; chk("R12 period", rd_data, 32'h1FE0);

    // R1/R2 key table
    for (int i = 0; i < 7; i++) begin
      wr(VECS[i].a, VECS[i].d);
      rd_addr = VECS[i].ra[AW-1:0]; #1;
      chk("R1/R2 table", rd_data, VECS[i].exp);
    end

    // R3 + R10 plain timeout, period 8 units = 32 ticks, pin active high
    do_reset();
    wr(8'h04, 32'h0000_0108);
    wr(8'h00, 32'h2200_0007);
    wait_hi(0, 40, n);
    chk("R3 expiry edges", n, 32);
    chk("R10 pin active high", {31'b0, ext_rst_o}, 1);
    n = 1;
    while (n < 40) begin @(posedge clk); #1; if (!rst_req_o) break; n++; end
    chk("R9 pulse width", n, PT);
    chk("R10 pin back idle", {31'b0, ext_rst_o}, 0);

    // R4 restart word
    do_reset();
    wr(8'h04, 32'h0000_0108);
    wr(8'h00, 32'h2200_0001);
    idle(19);
    wr(8'h08, 32'h0000_1971);
    wait_hi(0, 40, n);
    chk("R4 restart delays expiry", n, 32);

    // R4 near-miss restart word ignored
    do_reset();
    wr(8'h04, 32'h0000_0108);
    wr(8'h00, 32'h2200_0001);
    idle(19);
    wr(8'h08, 32'h0000_1970);
    wait_hi(0, 40, n);
    chk("R4 wrong word ignored", n, 12);

    // R5 length rewrite restarts
    do_reset();
    wr(8'h04, 32'h0000_0108);
    wr(8'h00, 32'h2200_0001);
    idle(19);
    wr(8'h04, 32'h0000_0088);
    wait_hi(0, 40, n);
    chk("R5 length write reloads new period", n, 16);

    // R3 zero period
    do_reset();
    wr(8'h04, 32'h0000_0008);
    wr(8'h00, 32'h2200_0001);
    wait_hi(0, 10, n);
    chk("R3 zero period", n, 1);

    // R6 dual mode two stages
    do_reset();
    wr(8'h04, 32'h0000_0108);
    wr(8'h00, 32'h2200_0049);
    wait_hi(1, 40, n);
    chk("R6 irq at first expiry", n, 32);
    chk("R6 no reset at first expiry", {31'b0, rst_req_o}, 0);
    wait_hi(0, 40, n);
    chk("R6 reset after second period", n, 32);
    chk("R6 irq held", {31'b0, irq_o}, 1);
    wr(8'h08, 32'h0000_1971);
    chk("R6 restart clears irq", {31'b0, irq_o}, 0);

    // R6 restart between stages returns to stage one
    do_reset();
    wr(8'h04, 32'h0000_0108);
    wr(8'h00, 32'h2200_0049);
    wait_hi(1, 40, n);
    idle(7);
    wr(8'h08, 32'h0000_1971);
    wait_hi(1, 40, n);
    chk("R6 irq again after restart", n, 32);
    chk("R6 no reset after restart", {31'b0, rst_req_o}, 0);
    wr(8'h00, 32'h2200_0049);
    chk("R6 mode write clears irq", {31'b0, irq_o}, 0);

    // R7 dual without interrupt enable
    do_reset();
    wr(8'h04, 32'h0000_0108);
    wr(8'h00, 32'h2200_0041);
    wait_hi(0, 40, n);
    chk("R7 single-stage expiry", n, 32);
    chk("R7 no irq", {31'b0, irq_o}, 0);

    // R8 software reset, timer disabled, pin disabled
    do_reset();
    wr(8'h14, 32'h0000_1208);
    chk("R8 wrong word no pulse", {31'b0, rst_req_o}, 0);
    wr(8'h00, 32'h2200_0002);
    wr(8'h14, 32'h0000_1209);
    chk("R8 immediate pulse", {31'b0, rst_req_o}, 1);
    chk("R10 pin disabled stays idle", {31'b0, ext_rst_o}, 0);

    // R10 active-low pin
    do_reset();
    wr(8'h00, 32'h2200_0004);
    wr(8'h14, 32'h0000_1209);
    chk("R10 pin active low", {31'b0, ext_rst_o}, 0);

    // R11 disable freezes
    do_reset();
    wr(8'h04, 32'h0000_0108);
    wr(8'h00, 32'h2200_0001);
    idle(9);
    wr(8'h00, 32'h2200_0000);
    idle(100);
    chk("R11 no expiry while disabled", {31'b0, rst_req_o}, 0);
    rd_addr = 5'h00; #1;
    chk("R11 enable reads 0", rd_data, 0);
    wr(8'h00, 32'h2200_0001);
    rd_addr = 5'h00; #1;
    chk("R11 enable reads 1", rd_data, 1);
    wait_hi(0, 40, n);
    chk("R11 re-enable full period", n, 32);

    // R11 no ticks, no progress
    do_reset();
    tick_en = 1'b0;
    wr(8'h04, 32'h0000_0028);
    wr(8'h00, 32'h2200_0001);
    idle(50);
    chk("R11 frozen without ticks", {31'b0, rst_req_o}, 0);
    @(negedge clk); tick_en = 1'b1;
    wait_hi(0, 10, n);
    chk("R11 counts once ticks resume", n, 4);

    finish_run();
  end

endmodule